// File: doc/BRIEF.md
# Busy Resource Countdown Tracker

This block keeps a small table of occupied execution resources, each with the number of cycles it still has to stay busy. An issue stage presents up to `ISSUE_PORTS` resource uses per cycle. Each use names a resource mask, the unit picked inside it and an occupancy in cycles. A use with a nonzero occupancy either adds its cycles to a live entry with the same key or takes a free table slot. A use of a whole reserved group is filed under the group mask paired with itself, and whatever unit value comes with it is ignored. A use with zero occupancy never enters the table and is handed straight back as a release.

On every clock edge all live counts drop by one. Entries that reach zero are retired and announced for exactly one cycle on a per-slot freed vector, together with their key. A retiring entry whose resource mask is a single unit also raises a unit-release bit. A slot that retires stays occupied for the rest of its retiring cycle, so neither a lookup nor an allocation in that cycle can use it. If an allocation finds no free slot, the request is dropped and an overflow flag pulses.

Top module: `busy_cd_tracker`

## Requirements
- R1: While reset is held and after its release, every output is zero and the table holds no entries.
- R2: A use with occupancy C ≥ 1 and a key not in the table takes a slot. If it is sampled at edge E, `freed_valid` for that slot is high for exactly the one cycle after edge E+C, and `freed_res`/`freed_unit` carry its key there. These fields are zero in every cycle where the slot's freed bit is low.
- R3: A use that needs a new slot when all `NUM_ENTRIES` slots are occupied raises `overflow` for one cycle and is dropped. Slots that retire on that same edge count as occupied.
- R4: A use whose key matches a live entry that is not retiring on that edge adds its occupancy to that entry's remaining count and takes no new slot.
- R5: A use with zero occupancy causes no table change. In the next cycle it raises `instant_release[p]`, with `instant_res[p]` equal to its resource mask. Both are zero otherwise.
- R6: A reserved-group use (`issue_reserved[p]`=1) is keyed as (resource mask, resource mask), and its `issue_unit[p]` has no effect.
- R7: `unit_release[i]` is high exactly when `freed_valid[i]` is high and the retired resource mask has exactly one bit set.
- R8: A use that arrives on the edge where an entry with the same key retires does not merge with it. It takes a different free slot.
- R9: Ports are handled from index 0 upward within a cycle. A new entry takes the lowest-numbered free slot, and a later port whose key matches an earlier port's entry from the same cycle adds to that entry.
- R10: An addition that would go past 2^BT_CNT_W − 1 saturates at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | ISSUE_PORTS | Use present on each port |
| issue_res | input | ISSUE_PORTS×BT_MASK_W | Resource mask of each use |
| issue_unit | input | ISSUE_PORTS×BT_MASK_W | Selected unit of each use |
| issue_reserved | input | ISSUE_PORTS | Use reserves the whole group |
| issue_cycles | input | ISSUE_PORTS×BT_CNT_W | Occupancy cycles of each use |
| freed_valid | output | NUM_ENTRIES | Per-slot retirement pulse |
| freed_res | output | NUM_ENTRIES×BT_MASK_W | Resource key of a retiring slot |
| freed_unit | output | NUM_ENTRIES×BT_MASK_W | Unit key of a retiring slot |
| unit_release | output | NUM_ENTRIES | Retiring slot also frees a single unit |
| instant_release | output | ISSUE_PORTS | Zero-occupancy use returned per port |
| instant_res | output | ISSUE_PORTS×BT_MASK_W | Resource mask of that returned use |
| overflow | output | 1 | A use found no free slot |

## Verification
The hardest state to reach is a full table in which some slots are retiring on the very edge where a fresh key or a matching key arrives. Reaching it checks that retiring slots are neither reused nor merged. The bench builds it on purpose. Sixteen distinct keys are filed in eight two-port cycles, with the first pair given an occupancy that makes it expire exactly when a new key and a repeat of an expiring key are presented. A long random phase with a small key space and short occupancies then keeps the table near its limit, so expiries, merges and overflows coincide repeatedly.

// File: rtl/bct_pkg.sv
`timescale 1ns/1ps
package bct_pkg;

    parameter int unsigned BT_MASK_W = 8;
    parameter int unsigned BT_CNT_W  = 8;

    typedef struct packed {
        logic                 vld;
        logic [BT_MASK_W-1:0] res;
        logic [BT_MASK_W-1:0] unit;
        logic [BT_CNT_W-1:0]  cnt;
    } bt_entry_t;

    function automatic logic bt_single_bit(input logic [BT_MASK_W-1:0] m);
        return (m != '0) && ((m & (m - BT_MASK_W'(1))) == '0);
    endfunction

endpackage

// File: rtl/bct_decay.sv
`timescale 1ns/1ps
// Ages every live slot by one cycle and flags the slots that hit zero.
module bct_decay import bct_pkg::*; #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input  bt_entry_t [NUM_ENTRIES-1:0] tbl_i,
    output bt_entry_t [NUM_ENTRIES-1:0] tbl_o,
    output logic      [NUM_ENTRIES-1:0] expire_o
);

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            tbl_o[i]    = tbl_i[i];
            expire_o[i] = 1'b0;
            if (tbl_i[i].vld) begin
                tbl_o[i].cnt = tbl_i[i].cnt - BT_CNT_W'(1);
                expire_o[i]  = (tbl_i[i].cnt == BT_CNT_W'(1));
            end
        end
    end

endmodule

// File: rtl/bct_alloc.sv
`timescale 1ns/1ps
// Applies one issue port to the working table: merge, allocate or overflow.
module bct_alloc import bct_pkg::*; #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input  bt_entry_t [NUM_ENTRIES-1:0] tbl_i,
    input  logic      [NUM_ENTRIES-1:0] hold_i,
    input  logic                        req_i,
    input  logic      [BT_MASK_W-1:0]   res_i,
    input  logic      [BT_MASK_W-1:0]   unit_i,
    input  logic                        group_i,
    input  logic      [BT_CNT_W-1:0]    cycles_i,
    output bt_entry_t [NUM_ENTRIES-1:0] tbl_o,
    output logic                        ovf_o,
    output logic                        zero_o
);

    localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [BT_MASK_W-1:0] key_unit;
    logic                 hit, has_free;
    logic [IDX_W-1:0]     hit_idx, free_idx;
    logic [BT_CNT_W:0]    sum;

    assign key_unit = group_i ? res_i : unit_i;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!hit && tbl_i[i].vld && !hold_i[i] &&
                tbl_i[i].res == res_i && tbl_i[i].unit == key_unit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!has_free && !tbl_i[i].vld) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        tbl_o  = tbl_i;
        ovf_o  = 1'b0;
        zero_o = 1'b0;
        sum    = {1'b0, tbl_i[hit_idx].cnt} + {1'b0, cycles_i};
        if (req_i) begin
            if (cycles_i == '0) begin
                zero_o = 1'b1;
            end else if (hit) begin
                tbl_o[hit_idx].cnt = sum[BT_CNT_W] ? '1 : sum[BT_CNT_W-1:0];
            end else if (has_free) begin
                tbl_o[free_idx].vld  = 1'b1;
                tbl_o[free_idx].res  = res_i;
                tbl_o[free_idx].unit = key_unit;
                tbl_o[free_idx].cnt  = cycles_i;
            end else begin
                ovf_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/busy_cd_tracker.sv
`timescale 1ns/1ps
module busy_cd_tracker import bct_pkg::*; #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ISSUE_PORTS = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ISSUE_PORTS-1:0]                issue_valid,
    input  logic [ISSUE_PORTS-1:0][BT_MASK_W-1:0] issue_res,
    input  logic [ISSUE_PORTS-1:0][BT_MASK_W-1:0] issue_unit,
    input  logic [ISSUE_PORTS-1:0]                issue_reserved,
    input  logic [ISSUE_PORTS-1:0][BT_CNT_W-1:0]  issue_cycles,
    output logic [NUM_ENTRIES-1:0]                freed_valid,
    output logic [NUM_ENTRIES-1:0][BT_MASK_W-1:0] freed_res,
    output logic [NUM_ENTRIES-1:0][BT_MASK_W-1:0] freed_unit,
    output logic [NUM_ENTRIES-1:0]                unit_release,
    output logic [ISSUE_PORTS-1:0]                instant_release,
    output logic [ISSUE_PORTS-1:0][BT_MASK_W-1:0] instant_res,
    output logic                                  overflow
);

    typedef struct packed {
        bt_entry_t [NUM_ENTRIES-1:0]                tbl;
        logic      [NUM_ENTRIES-1:0]                fv;
        logic      [NUM_ENTRIES-1:0][BT_MASK_W-1:0] fres;
        logic      [NUM_ENTRIES-1:0][BT_MASK_W-1:0] funit;
        logic      [NUM_ENTRIES-1:0]                urel;
        logic      [ISSUE_PORTS-1:0]                irel;
        logic      [ISSUE_PORTS-1:0][BT_MASK_W-1:0] ires;
        logic                                       ovf;
    } state_t;

    state_t st_d, st_q;

    bt_entry_t [NUM_ENTRIES-1:0] aged;
    logic      [NUM_ENTRIES-1:0] expiring;
    bt_entry_t [NUM_ENTRIES-1:0] chain [ISSUE_PORTS+1];
    logic      [ISSUE_PORTS-1:0] port_ovf;
    logic      [ISSUE_PORTS-1:0] port_zero;

    bct_decay #(.NUM_ENTRIES(NUM_ENTRIES)) u_decay (
        .tbl_i    (st_q.tbl),
        .tbl_o    (aged),
        .expire_o (expiring)
    );

    assign chain[0] = aged;

    generate
        for (genvar p = 0; p < ISSUE_PORTS; p++) begin : g_port
            bct_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
                .tbl_i    (chain[p]),
                .hold_i   (expiring),
                .req_i    (issue_valid[p]),
                .res_i    (issue_res[p]),
                .unit_i   (issue_unit[p]),
                .group_i  (issue_reserved[p]),
                .cycles_i (issue_cycles[p]),
                .tbl_o    (chain[p+1]),
                .ovf_o    (port_ovf[p]),
                .zero_o   (port_zero[p])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.tbl = chain[ISSUE_PORTS];
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            st_d.fv[i]    = expiring[i];
            st_d.fres[i]  = expiring[i] ? st_q.tbl[i].res  : '0;
            st_d.funit[i] = expiring[i] ? st_q.tbl[i].unit : '0;
            st_d.urel[i]  = expiring[i] && bt_single_bit(st_q.tbl[i].res);
            if (expiring[i]) begin
                st_d.tbl[i] = '0;
            end
        end
        for (int p = 0; p < ISSUE_PORTS; p++) begin
            st_d.irel[p] = port_zero[p];
            st_d.ires[p] = port_zero[p] ? issue_res[p] : '0;
        end
        st_d.ovf = |port_ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freed_valid     = st_q.fv;
    assign freed_res       = st_q.fres;
    assign freed_unit      = st_q.funit;
    assign unit_release    = st_q.urel;
    assign instant_release = st_q.irel;
    assign instant_res     = st_q.ires;
    assign overflow        = st_q.ovf;

endmodule

// File: rtl/bct_chk.sv
`timescale 1ns/1ps
module bct_chk import bct_pkg::*; #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ISSUE_PORTS = 2
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [ISSUE_PORTS-1:0]                issue_valid,
    input logic [ISSUE_PORTS-1:0][BT_CNT_W-1:0]  issue_cycles,
    input logic [NUM_ENTRIES-1:0]                freed_valid,
    input logic [NUM_ENTRIES-1:0][BT_MASK_W-1:0] freed_res,
    input logic [NUM_ENTRIES-1:0]                unit_release,
    input logic [ISSUE_PORTS-1:0]                instant_release,
    input logic                                  overflow,
    input bt_entry_t [NUM_ENTRIES-1:0]           tbl_q
);

    generate
        for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
            // R2: a retirement pulse never lasts two cycles on one slot
            assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
                freed_valid[i] |=> !freed_valid[i]);
            // R2: a live slot always has cycles left
            assert_live_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tbl_q[i].vld |-> (tbl_q[i].cnt != '0));
            // R7: unit release only with a one-bit resource key being freed
            assert_unit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                unit_release[i] |-> (freed_valid[i] && $countones(freed_res[i]) == 1));
        end
        for (genvar p = 0; p < ISSUE_PORTS; p++) begin : g_prt
            // R5: an instant release comes only from a zero-occupancy use
            assert_zero_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
                instant_release[p] |-> $past(issue_valid[p] && issue_cycles[p] == '0));
        end
    endgenerate

    // R3: overflow needs a nonzero-occupancy request on the previous edge
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(|(issue_valid & ~instant_release_mask(issue_cycles))));

    function automatic logic [ISSUE_PORTS-1:0] instant_release_mask(
        input logic [ISSUE_PORTS-1:0][BT_CNT_W-1:0] cyc);
        for (int p = 0; p < ISSUE_PORTS; p++) instant_release_mask[p] = (cyc[p] == '0);
    endfunction

endmodule

bind busy_cd_tracker bct_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ISSUE_PORTS (ISSUE_PORTS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .issue_valid     (issue_valid),
    .issue_cycles    (issue_cycles),
    .freed_valid     (freed_valid),
    .freed_res       (freed_res),
    .unit_release    (unit_release),
    .instant_release (instant_release),
    .overflow        (overflow),
    .tbl_q           (st_q.tbl)
);

// File: tb/tb_busy_cd_tracker.sv
`timescale 1ns/1ps
module tb_busy_cd_tracker;
    import bct_pkg::*;

    localparam int N   = 16;
    localparam int P   = 2;
    localparam int MW  = BT_MASK_W;
    localparam int CW  = BT_CNT_W;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P-1:0]         issue_valid;
    logic [P-1:0][MW-1:0] issue_res, issue_unit;
    logic [P-1:0]         issue_reserved;
    logic [P-1:0][CW-1:0] issue_cycles;
    logic [N-1:0]         freed_valid, unit_release;
    logic [N-1:0][MW-1:0] freed_res, freed_unit;
    logic [P-1:0]         instant_release;
    logic [P-1:0][MW-1:0] instant_res;
    logic                 overflow;

    busy_cd_tracker #(.NUM_ENTRIES(N), .ISSUE_PORTS(P)) dut (.*);

    always #2 clk = ~clk;

    // behavioural model
    bit mv[N];
    int mres[N], munit[N], mcnt[N];
    logic [N-1:0]         e_fv, e_ur;
    logic [N-1:0][MW-1:0] e_fr, e_fu;
    logic [P-1:0]         e_ir;
    logic [P-1:0][MW-1:0] e_irs;
    logic                 e_ov;

    int n_cmp = 0, n_bad = 0;
    bit ended = 0;
    string cur_tag = "R1";

    task automatic model_clear_out();
        e_fv = '0; e_ur = '0; e_fr = '0; e_fu = '0; e_ir = '0; e_irs = '0; e_ov = 1'b0;
    endtask

    task automatic model_step();
        bit gone[N];
        int ku;
        bit done;
        model_clear_out();
        for (int i = 0; i < N; i++) begin
            gone[i] = 0;
            if (mv[i]) begin
                mcnt[i]--;
                if (mcnt[i] == 0) begin
                    gone[i] = 1;
                    e_fv[i] = 1'b1;
                    e_fr[i] = MW'(mres[i]);
                    e_fu[i] = MW'(munit[i]);
                    e_ur[i] = ($countones(mres[i]) == 1);
                end
            end
        end
        for (int p = 0; p < P; p++) begin
            if (issue_valid[p]) begin
                ku = issue_reserved[p] ? int'(issue_res[p]) : int'(issue_unit[p]);
                if (issue_cycles[p] == '0) begin
                    e_ir[p]  = 1'b1;
                    e_irs[p] = issue_res[p];
                end else begin
                    done = 0;
                    for (int i = 0; i < N; i++)
                        if (!done && mv[i] && !gone[i] && mres[i] == int'(issue_res[p]) && munit[i] == ku) begin
                            mcnt[i] += int'(issue_cycles[p]);
                            if (mcnt[i] > MAXC) mcnt[i] = MAXC;
                            done = 1;
                        end
                    for (int i = 0; i < N; i++)
                        if (!done && !mv[i]) begin
                            mv[i] = 1; mres[i] = int'(issue_res[p]); munit[i] = ku;
                            mcnt[i] = int'(issue_cycles[p]);
                            done = 1;
                        end
                    if (!done) e_ov = 1'b1;
                end
            end
        end
        for (int i = 0; i < N; i++) if (gone[i]) mv[i] = 0;
    endtask

    task automatic check(string what, logic [255:0] act, logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("freed_valid (R2)",          256'(freed_valid),     256'(e_fv));
        check("freed_res (R2)",            256'(freed_res),       256'(e_fr));
        check("freed_unit (R2/R6)",        256'(freed_unit),      256'(e_fu));
        check("unit_release (R7)",         256'(unit_release),    256'(e_ur));
        check("instant_release (R5)",      256'(instant_release), 256'(e_ir));
        check("instant_res (R5)",          256'(instant_res),     256'(e_irs));
        check("overflow (R3)",             256'(overflow),        256'(e_ov));
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic drive(int p, int res, int unit, bit rsv, int cyc);
        issue_valid[p]    = 1'b1;
        issue_res[p]      = MW'(res);
        issue_unit[p]     = MW'(unit);
        issue_reserved[p] = rsv;
        issue_cycles[p]   = CW'(cyc);
    endtask

    task automatic clr();
        issue_valid = '0; issue_res = '0; issue_unit = '0;
        issue_reserved = '0; issue_cycles = '0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL [watchdog] run did not finish: actual hung expected done");
        finish_run();
    end

    initial begin
        clr();
        for (int i = 0; i < N; i++) begin mv[i] = 0; mres[i] = 0; munit[i] = 0; mcnt[i] = 0; end
        model_clear_out();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        compare_all();
        rst_n = 1'b1;
        step(2);

        // R2 and R7: one-bit key, 3 cycles
        cur_tag = "R2";
        drive(0, 'h04, 'h04, 0, 3); step(1); clr(); step(5);
        // R7: two-bit resource key gives no unit release
        cur_tag = "R7";
        drive(1, 'h06, 'h02, 0, 2); step(1); clr(); step(4);

        // R5: zero occupancy on both ports, including a reserved one
        cur_tag = "R5";
        drive(0, 'h10, 'h10, 0, 0); drive(1, 'h30, 'h01, 1, 0); step(1); clr(); step(2);

        // R6: reserved group ignores the unit input
        cur_tag = "R6";
        drive(0, 'h30, 'h01, 1, 2); step(1);
        drive(0, 'h30, 'h02, 1, 3); step(1); clr(); step(6);

        // R4: merge into live entry
        cur_tag = "R4";
        drive(0, 'h01, 'h01, 0, 5); step(1); clr(); step(2);
        drive(1, 'h01, 'h01, 0, 3); step(1); clr(); step(8);

        // R9: both ports same key and different keys in one cycle
        cur_tag = "R9";
        drive(0, 'h02, 'h02, 0, 2); drive(1, 'h02, 'h02, 0, 3); step(1); clr(); step(7);
        drive(0, 'h08, 'h08, 0, 4); drive(1, 'h0C, 'h04, 0, 2); step(1); clr(); step(6);

        // R8: same key arrives on the edge it retires
        cur_tag = "R8";
        drive(0, 'h40, 'h40, 0, 2); step(1); clr(); step(1);
        drive(0, 'h40, 'h40, 0, 3); step(1); clr(); step(5);

        // R10: saturation
        cur_tag = "R10";
        drive(0, 'h80, 'h80, 0, 200); drive(1, 'h80, 'h80, 0, 200); step(1); clr();
        step(MAXC + 3);

        // R3: full table, first pair retiring when a new key arrives
        cur_tag = "R3";
        for (int k = 0; k < 8; k++) begin
            drive(0, 1 << (k % 8), 'h01 + 2 * k, 0, (k == 0) ? 8 : 40);
            drive(1, 1 << (k % 8), 'h02 + 2 * k, 0, (k == 0) ? 8 : 40);
            step(1);
        end
        drive(0, 'hFF, 'h77, 0, 4);           // new key: overflow
        drive(1, 'h01, 'h01, 0, 4);           // retiring key: no merge, no slot (R8)
        step(1);
        drive(0, 'h02, 'h04, 0, 5);           // live key: merge while full (R4)
        drive(1, 'hFE, 'h01, 0, 3);           // now takes a freed slot
        step(1); clr(); step(50);

        // R9: random pressure
        cur_tag = "R9";
        for (int k = 0; k < 3000; k++) begin
            clr();
            for (int p = 0; p < P; p++)
                if (($urandom % 10) < 6) begin
                    int sel;
                    sel = int'($urandom % 6);
                    drive(p, (sel < 4) ? (1 << sel) : ((sel == 4) ? 'h0C : 'h30),
                          1 << ($urandom % 3), (($urandom % 8) == 0), int'($urandom % 12));
                end
            step(1);
        end
        clr(); step(20);
        finish_run();
    end

endmodule